// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block holds seven sticky interrupt request flags in one 8-bit register. Each flag has its own source. The timer flag sets when the 8-bit timer count wraps from 0xFF to 0x00. The serial flag sets on a transfer-done pulse. Five pin flags each set on the chosen edge of an external interrupt pin, but only while that pin is enabled as an interrupt input. Software reads the register through `rd_data`. It clears a flag by writing 0 to that flag's bit. Every flag also drives its own request line, which the interrupt controller samples.

Each flag is a small two-state machine with the states `FLAG_IDLE` and `FLAG_PENDING`. There are three transitions:
- `SET`: `FLAG_IDLE` goes to `FLAG_PENDING` on a hardware event.
- `CLEAR`: `FLAG_PENDING` goes to `FLAG_IDLE` on a write of 0 with no event in the same cycle.
- `HOLD`: the state stays as it is in all other cases. A hardware event that arrives together with a clear also holds the state in `FLAG_PENDING`.

Pins pass through a synchronizer before edge detection. When the parameter `FULL_VARIANT` is 0, the serial flag (bit 6) and pin 2's flag (bit 2) are built as constant zero.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x20 and every request output is low.
- R2: Bit 7 (the timer flag) sets in the cycle after `tmr_count` moves from 0xFF to 0x00. No other change of count sets it, including 0xFE→0xFF, 0x00→0x01 and 0x05→0x00.
- R3: Bit 6 (the serial flag) sets in the cycle after `ser_done` is sampled high.
- R4: Pin flag n (bit n, n = 0 to 4) sets when `pin_irq_en[n]`=1 and the selected edge occurs on `irq_pin[n]`. `pin_edge_rise[n]`=1 selects the rising edge and 0 selects the falling edge. The flag is visible no later than the third rising clock edge after the pin changes.
- R5: A pin whose `pin_irq_en` bit is 0 never sets its flag, whatever edges occur on it.
- R6: A write (`wr_en`=1) clears every flag whose `wr_data` bit is 0.
- R7: A write with a 1 in a flag's bit leaves that flag unchanged.
- R8: When a hardware set event and a write-0 clear hit the same flag in the same cycle, the flag ends up set.
- R9: Bit 5 always reads 1, and writes to it have no effect.
- R10: `tmr_req`, `ser_req` and `pin_req[n]` are high exactly while bits 7, 6 and n of `rd_data` are 1.
- R11: With `FULL_VARIANT`=0, bits 6 and 2 stay 0 whatever their sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count | input | 8 | Current value of the timer counter |
| ser_done | input | 1 | Serial transfer-complete pulse |
| irq_pin | input | 5 | Raw external interrupt pins |
| pin_irq_en | input | 5 | Per-pin enable as an interrupt input |
| pin_edge_rise | input | 5 | Per-pin edge select: 1 = rising, 0 = falling |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 bit clears that flag |
| rd_data | output | 8 | Register read value |
| tmr_req | output | 1 | Timer request line |
| ser_req | output | 1 | Serial request line |
| pin_req | output | 5 | Pin request lines |

## Verification
The assertions assume three things about the inputs:
- Pins are low during reset, so the synchronizer's reset value does not create an edge.
- `ser_done` and `wr_en` are only meaningful once reset is released.
- The timer count moves one value per cycle when the bench presents a wrap.

The stimulus holds the pins low through reset. It changes pin configuration only while the pins are steady, and it holds each new pin level for four cycles before checking, so that every edge has passed the synchronizer. Timer pairs and write data are drawn from `$urandom` within those rules.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;

    localparam int REG_W    = 8;
    localparam int TMR_BIT  = 7;
    localparam int SER_BIT  = 6;
    localparam int RSV_BIT  = 5;
endpackage

// File: rtl/irqf_pin_edge.sv
module irqf_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic en_i,
    input  logic rise_sel_i,
    output logic hit_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic              rise_w;
    logic              fall_w;

    // Synchronizer chain, then one more flop that keeps the previous
    // synchronized level for edge detection.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[TOP];
    end

    always_comb begin
        rise_w = chain_q[TOP] & ~prev_q;
        fall_w = ~chain_q[TOP] & prev_q;
        hit_o  = en_i & (rise_sel_i ? rise_w : fall_w);
    end

    // R5: a disabled pin never reports an edge hit
    a_r5_no_hit_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !hit_o);
endmodule

// File: rtl/irqf_wrap_detect.sv
module irqf_wrap_detect #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= count_i;
    end

    always_comb wrap_o = (last_q == CNT_MAX) && (count_i == '0);
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // SET, CLEAR and HOLD transitions; a set event outranks a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_i) state_d = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                if (clr_i && !set_i) state_d = FLAG_IDLE;
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FLAG_PENDING);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    a_r7_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irqf_pkg::*;
#(
    parameter int NUM_PINS     = 5,
    parameter int SYNC_STAGES  = 2,
    parameter int TMR_W        = 8,
    parameter bit FULL_VARIANT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TMR_W-1:0]    tmr_count,
    input  logic                ser_done,
    input  logic [NUM_PINS-1:0] irq_pin,
    input  logic [NUM_PINS-1:0] pin_irq_en,
    input  logic [NUM_PINS-1:0] pin_edge_rise,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic                tmr_req,
    output logic                ser_req,
    output logic [NUM_PINS-1:0] pin_req
);
    localparam logic [REG_W-1:0] USED_MASK = FULL_VARIANT ? 8'hDF : 8'h9B;

    logic [REG_W-1:0]    set_w;
    logic [REG_W-1:0]    clr_w;
    logic [REG_W-1:0]    flag_w;
    logic [NUM_PINS-1:0] hit_w;
    logic                wrap_w;

    irqf_wrap_detect #(.CNT_W(TMR_W)) u_wrap (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (tmr_count),
        .wrap_o  (wrap_w)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            irqf_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin_i      (irq_pin[p]),
                .en_i       (pin_irq_en[p]),
                .rise_sel_i (pin_edge_rise[p]),
                .hit_o      (hit_w[p])
            );
        end
    endgenerate

    always_comb begin
        set_w                = '0;
        set_w[NUM_PINS-1:0]  = hit_w;
        set_w[SER_BIT]       = ser_done;
        set_w[TMR_BIT]       = wrap_w;
        clr_w                = {REG_W{wr_en}} & ~wr_data;
    end

    generate
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            if (USED_MASK[b]) begin : g_cell
                irqf_flag_cell u_cell (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .set_i  (set_w[b]),
                    .clr_i  (clr_w[b]),
                    .flag_o (flag_w[b])
                );
            end else begin : g_tie
                assign flag_w[b] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rd_data          = flag_w;
        rd_data[RSV_BIT] = 1'b1;
        tmr_req          = flag_w[TMR_BIT];
        ser_req          = flag_w[SER_BIT];
        pin_req          = flag_w[NUM_PINS-1:0];
    end

    a_r9_reserved_one: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RSV_BIT]);
    a_r2_wrap_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_req) |-> ($past(tmr_count) == '0));
    a_r3_serial_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_done && USED_MASK[SER_BIT]) |=> ser_req);

    generate
        for (genvar q = 0; q < NUM_PINS; q++) begin : g_chk
            a_r5_off_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (!pin_irq_en[q] && !pin_req[q]) |=> !pin_req[q]);
        end
        if (!FULL_VARIANT) begin : g_lite_chk
            a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_data[SER_BIT] && !rd_data[2]);
        end
    endgenerate
endmodule

// File: tb/irq_flag_reg_test.sv
module irq_flag_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tmr_count = 8'h10;
    logic       ser_done = 1'b0;
    logic [4:0] irq_pin = 5'b0;
    logic [4:0] pin_irq_en = 5'b0;
    logic [4:0] pin_edge_rise = 5'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'hFF;
    logic [7:0] rd_data, rd_lite;
    logic       tmr_req, ser_req, tmr_lite, ser_lite;
    logic [4:0] pin_req, pin_lite;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model;

    always #10 clk = ~clk;

    irq_flag_reg uut (
        .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .ser_done(ser_done),
        .irq_pin(irq_pin), .pin_irq_en(pin_irq_en), .pin_edge_rise(pin_edge_rise),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .tmr_req(tmr_req), .ser_req(ser_req), .pin_req(pin_req));

    irq_flag_reg #(.FULL_VARIANT(1'b0)) uut_lite (
        .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .ser_done(ser_done),
        .irq_pin(irq_pin), .pin_irq_en(pin_irq_en), .pin_edge_rise(pin_edge_rise),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_lite),
        .tmr_req(tmr_lite), .ser_req(ser_lite), .pin_req(pin_lite));

    initial begin
        #3000000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [7:0] view(input logic [7:0] flags);
        return (flags & 8'hDF) | 8'h20;
    endfunction

    function automatic logic [4:0] pin_hits(input logic [4:0] oldv, input logic [4:0] newv,
                                            input logic [4:0] en, input logic [4:0] rise);
        return en & ((rise & ~oldv & newv) | (~rise & oldv & ~newv));
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        logic [7:0] lite_exp;
        checks++;
        lite_exp = exp & 8'hBB;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data actual %h expected %h", req, rd_data, exp);
        end
        if (rd_lite !== lite_exp) begin
            fails++;
            $display("FAIL R11 (%s): lite rd_data actual %h expected %h", req, rd_lite, lite_exp);
        end
        if ({tmr_req, ser_req, pin_req} !== {exp[7], exp[6], exp[4:0]}) begin
            fails++;
            $display("FAIL R10 (%s): req actual %b expected %b", req,
                     {tmr_req, ser_req, pin_req}, {exp[7], exp[6], exp[4:0]});
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'hFF;
        for (int i = 0; i < 8; i++) if (!d[i]) model[i] = 1'b0;
    endtask

    task automatic tmr_pair(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); tmr_count = a;
        @(negedge clk); tmr_count = b;
        @(negedge clk);
        if (a == 8'hFF && b == 8'h00) model[7] = 1'b1;
        tmr_count = 8'h10;
        @(negedge clk);
    endtask

    task automatic pins_to(input logic [4:0] v);
        logic [4:0] h;
        h = pin_hits(irq_pin, v, pin_irq_en, pin_edge_rise);
        @(negedge clk); irq_pin = v;
        cyc(4);
        model[4:0] = model[4:0] | h;
    endtask

    initial begin
        model = 8'h00;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 reset", 8'h20);

        tmr_pair(8'hFE, 8'hFF); check("R2 FE->FF", view(model));
        tmr_pair(8'h00, 8'h01); check("R2 00->01", view(model));
        tmr_pair(8'h05, 8'h00); check("R2 05->00", view(model));
        tmr_pair(8'hFF, 8'h00); check("R2 FF->00", view(model));

        @(negedge clk); ser_done = 1'b1;
        @(negedge clk); ser_done = 1'b0; model[6] = 1'b1;
        check("R3 serial done", view(model));

        pin_irq_en = 5'b11111; pin_edge_rise = 5'b10101;
        cyc(2);
        pins_to(5'b11111); check("R4 rising edges", view(model));
        pins_to(5'b00000); check("R4 falling edges", view(model));

        wr(8'h00); check("R6 clear all", view(model));
        wr(8'h20); check("R9 write bit5", 8'h20);

        pin_irq_en = 5'b00000;
        cyc(2);
        pins_to(5'b11111); check("R5 disabled rise", view(model));
        pins_to(5'b00000); check("R5 disabled fall", view(model));

        tmr_pair(8'hFF, 8'h00);
        @(negedge clk); ser_done = 1'b1;
        @(negedge clk); ser_done = 1'b0; model[6] = 1'b1;
        wr(8'hFF); check("R7 write ones", view(model));

        // R8: serial event and clear of bit 6 in one cycle
        wr(8'h00); check("R6 clear before R8", view(model));
        @(negedge clk); ser_done = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk); ser_done = 1'b0; wr_en = 1'b0; wr_data = 8'hFF;
        model[6] = 1'b1;
        check("R8 set beats clear", view(model));

        void'($urandom(32'd1234));
        for (int it = 0; it < 200; it++) begin
            logic [7:0] r;
            r = 8'($urandom);
            pin_irq_en = 5'($urandom); pin_edge_rise = 5'($urandom);
            cyc(2);
            pins_to(5'($urandom));
            if (r[0]) tmr_pair(8'hFF, 8'h00); else tmr_pair(8'($urandom), 8'($urandom));
            if (r[1]) begin
                @(negedge clk); ser_done = 1'b1;
                @(negedge clk); ser_done = 1'b0; model[6] = 1'b1;
            end
            check("R4 random events", view(model));
            wr(8'($urandom)); check("R6 random write", view(model));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule